// File: doc/BRIEF.md
# Vector Configuration and Length Controller

This block keeps the configuration state of a vector execution unit and owns its vector length register. A single command port accepts four operations: configure, set-length, read-length and write-length. Each operation carries one operand word and produces one result word and an illegal flag. The configure operation takes an 8-bit immediate. From it the block derives how many vector registers are enabled, the widest element size, the fixed-point clip mode and the largest vector length that the register file can hold.

The register file has a fixed byte budget, set by a parameter. The largest vector length is that budget divided by the product of the enabled register count and the element size in bytes, rounded down. It is worked out at run time for each configuration. Every length request is clamped against it. The current configuration and both lengths are always visible on status outputs. A surrounding pipeline decodes instructions, issues commands here and turns the illegal flag into a trap.

Top module: `vcfg_len_ctrl`

## Requirements
- R1: After a synchronous reset the unit is disabled. `vreg_top`, `ew_code`, `clip_mode`, `round_mode`, `max_vl` and `cur_vl` are all zero, and `rsp_valid` and `rsp_illegal` are low.
- R2: A configure (`cmd_op` 2'b00) whose operand bits [4:0] hold a nonzero value n enables the unit. It reports n on `vreg_top`, meaning registers 0 to n are enabled (n+1 in all). It copies operand bits [6:5] to `ew_code`, copies operand bit [7] to `clip_mode`, and sets `round_mode` to 2'b10.
- R3: A configure whose operand bits [4:0] are zero disables the unit. It clears `vreg_top`, `ew_code`, `clip_mode`, `round_mode`, `max_vl` and `cur_vl`, and returns 0.
- R4: For an enabling configure, `max_vl` equals floor(CAP_BYTES / ((n+1) × B)). B is the element size in bytes given by bits [6:5]: 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 4 and 2'b00 gives 8.
- R5: A configure sets `cur_vl` to the new `max_vl` and returns that value as its result.
- R6: A set-length (`cmd_op` 2'b01) treats its operand as unsigned. It writes min(operand, `max_vl`) into `cur_vl` and returns the same value.
- R7: A read-length (`cmd_op` 2'b10) returns `cur_vl` and leaves it unchanged.
- R8: A write-length (`cmd_op` 2'b11) sets `cur_vl` to min(operand, `max_vl`) and returns the value `cur_vl` held before the write.
- R9: While the unit is disabled, a set-length, read-length or write-length raises `rsp_illegal`, returns 0 and leaves `cur_vl` at 0.
- R10: A command accepted at a clock edge is answered at that same edge. `rsp_valid`, `rsp_result`, `rsp_illegal` and the status outputs change together, and `rsp_valid` is high for exactly one cycle per command. `rsp_illegal` is low for every legal command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 configure, 01 set-length, 10 read-length, 11 write-length |
| cmd_operand | input | XLEN | Immediate (configure) or requested length |
| rsp_valid | output | 1 | Response present |
| rsp_result | output | XLEN | Result word, zero-extended |
| rsp_illegal | output | 1 | Command was illegal in the current state |
| vu_enabled | output | 1 | Vector unit enabled |
| vreg_top | output | 5 | Highest enabled register index |
| ew_code | output | 2 | Maximum element width code |
| clip_mode | output | 1 | Fixed-point clip mode |
| round_mode | output | 2 | Fixed-point rounding mode |
| max_vl | output | VLW | Largest vector length for the current configuration |
| cur_vl | output | VLW | Current vector length |

## Verification
Each result is due exactly one clock edge after its command is sampled. The response word, the illegal flag, the new length and the new configuration all appear together after that edge. The bench drives a command on a falling edge, drops `cmd_valid` on the next falling edge and samples every output at that moment. Because of this, every expected value is compared in the one cycle when it becomes visible. One extra idle sample confirms that `rsp_valid` drops after a single cycle.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned NREG_SL = 32;

  typedef enum logic [1:0] {
    OP_CFG   = 2'b00,
    OP_SETVL = 2'b01,
    OP_RDVL  = 2'b10,
    OP_WRVL  = 2'b11
  } vcmd_e;

  localparam logic [1:0] RM_NEAR_EVEN = 2'b10;
endpackage

// File: rtl/vcfg_imm_decode.sv
module vcfg_imm_decode
  import vcfg_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  output logic             en,
  output logic [IDX_W-1:0] top_idx,
  output logic [1:0]       ew,
  output logic             clip,
  output logic [1:0]       bytes_log2
);
  always_comb begin
    top_idx    = imm[IDX_W-1:0];
    en         = (top_idx != '0);
    ew         = imm[6:5];
    clip       = imm[7];
    // 01->1B, 10->2B, 11->4B, 00->8B : log2 bytes is code minus one, mod 4
    bytes_log2 = ew - 2'd1;
  end
endmodule

// File: rtl/vcfg_maxvl_calc.sv
module vcfg_maxvl_calc
  import vcfg_pkg::*;
#(
  parameter int unsigned CAP_BYTES = 512,
  parameter int unsigned VLW       = 9
) (
  input  logic [IDX_W-1:0] top_idx,
  input  logic [1:0]       bytes_log2,
  output logic [VLW-1:0]   maxvl
);
  // Quotient of the byte budget by each register count, fixed at elaboration.
  logic [VLW-1:0] per_reg [NREG_SL];

  for (genvar gi = 0; gi < NREG_SL; gi++) begin : g_quot
    if (gi == 0) begin : g_off
      assign per_reg[gi] = '0;
    end else begin : g_on
      localparam int unsigned QUOT = CAP_BYTES / (gi + 1);
      assign per_reg[gi] = VLW'(QUOT);
    end
  end

  // floor(floor(C/n)/2^k) == floor(C/(n*2^k))
  assign maxvl = per_reg[top_idx] >> bytes_log2;
endmodule

// File: rtl/vcfg_len_clamp.sv
module vcfg_len_clamp #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLW  = 9
) (
  input  logic [XLEN-1:0] req,
  input  logic [VLW-1:0]  limit,
  output logic [VLW-1:0]  granted
);
  localparam int unsigned PADW = XLEN - VLW;
  logic [XLEN-1:0] limit_wide;

  always_comb begin
    limit_wide = {{PADW{1'b0}}, limit};
    granted    = (req > limit_wide) ? limit : req[VLW-1:0];
  end
endmodule

// File: rtl/vcfg_len_ctrl.sv
module vcfg_len_ctrl
  import vcfg_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CAP_BYTES = 512,
  localparam int unsigned VLW      = $clog2(CAP_BYTES / 2 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [XLEN-1:0]  cmd_operand,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_result,
  output logic             rsp_illegal,
  output logic             vu_enabled,
  output logic [IDX_W-1:0] vreg_top,
  output logic [1:0]       ew_code,
  output logic             clip_mode,
  output logic [1:0]       round_mode,
  output logic [VLW-1:0]   max_vl,
  output logic [VLW-1:0]   cur_vl
);
  logic             dec_en;
  logic [IDX_W-1:0] dec_top;
  logic [1:0]       dec_ew;
  logic             dec_clip;
  logic [1:0]       dec_shift;
  logic [VLW-1:0]   calc_max;
  logic [VLW-1:0]   clamped;

  vcfg_imm_decode u_dec (
    .imm        (cmd_operand[IMM_W-1:0]),
    .en         (dec_en),
    .top_idx    (dec_top),
    .ew         (dec_ew),
    .clip       (dec_clip),
    .bytes_log2 (dec_shift)
  );

  vcfg_maxvl_calc #(.CAP_BYTES(CAP_BYTES), .VLW(VLW)) u_max (
    .top_idx    (dec_top),
    .bytes_log2 (dec_shift),
    .maxvl      (calc_max)
  );

  vcfg_len_clamp #(.XLEN(XLEN), .VLW(VLW)) u_clamp (
    .req     (cmd_operand),
    .limit   (max_vl),
    .granted (clamped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_result  <= '0;
      rsp_illegal <= 1'b0;
      vu_enabled  <= 1'b0;
      vreg_top    <= '0;
      ew_code     <= '0;
      clip_mode   <= 1'b0;
      round_mode  <= '0;
      max_vl      <= '0;
      cur_vl      <= '0;
    end else begin
      rsp_valid   <= cmd_valid;
      rsp_result  <= '0;
      rsp_illegal <= 1'b0;
      if (cmd_valid) begin
        case (vcmd_e'(cmd_op))
          OP_CFG: begin
            if (dec_en) begin
              vu_enabled <= 1'b1;
              vreg_top   <= dec_top;
              ew_code    <= dec_ew;
              clip_mode  <= dec_clip;
              round_mode <= RM_NEAR_EVEN;
              max_vl     <= calc_max;
              cur_vl     <= calc_max;
              rsp_result <= XLEN'(calc_max);
            end else begin
              vu_enabled <= 1'b0;
              vreg_top   <= '0;
              ew_code    <= '0;
              clip_mode  <= 1'b0;
              round_mode <= '0;
              max_vl     <= '0;
              cur_vl     <= '0;
            end
          end
          OP_SETVL: begin
            if (!vu_enabled) begin
              rsp_illegal <= 1'b1;
            end else begin
              cur_vl     <= clamped;
              rsp_result <= XLEN'(clamped);
            end
          end
          OP_RDVL: begin
            if (!vu_enabled) rsp_illegal <= 1'b1;
            else             rsp_result  <= XLEN'(cur_vl);
          end
          default: begin
            if (!vu_enabled) begin
              rsp_illegal <= 1'b1;
            end else begin
              cur_vl     <= clamped;
              rsp_result <= XLEN'(cur_vl);
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vcfg_len_ctrl_chk.sv
module vcfg_len_ctrl_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned VLW  = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_result,
  input logic            rsp_illegal,
  input logic            vu_enabled,
  input logic [1:0]      round_mode,
  input logic [VLW-1:0]  max_vl,
  input logic [VLW-1:0]  cur_vl
);
  AST_VL_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst)
    cur_vl <= max_vl); // R6

  AST_OFF_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    !vu_enabled |-> (cur_vl == '0 && max_vl == '0)); // R3

  AST_ON_ROUND_NE: assert property (@(posedge clk) disable iff (rst)
    vu_enabled |-> round_mode == 2'b10); // R2

  AST_CFG_LOADS_MAX: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b00) |=> (cur_vl == max_vl && rsp_result == XLEN'(max_vl))); // R5

  AST_OFF_CMD_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != 2'b00 && !vu_enabled) |=> (rsp_illegal && $stable(cur_vl))); // R9

  AST_ON_CMD_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == 2'b00 || vu_enabled)) |=> !rsp_illegal); // R10

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid); // R10

  AST_RSP_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!rsp_valid && !rsp_illegal)); // R10

  AST_READ_KEEPS_VL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'b10) |=> $stable(cur_vl)); // R7
endmodule

bind vcfg_len_ctrl vcfg_len_ctrl_chk #(.XLEN(XLEN), .VLW(VLW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .rsp_valid   (rsp_valid),
  .rsp_result  (rsp_result),
  .rsp_illegal (rsp_illegal),
  .vu_enabled  (vu_enabled),
  .round_mode  (round_mode),
  .max_vl      (max_vl),
  .cur_vl      (cur_vl)
);

// File: tb/vcfg_len_ctrl_tb.sv
module vcfg_len_ctrl_tb;
  localparam int unsigned XLEN = 32;
  localparam int unsigned CAP  = 512;
  localparam int unsigned VLW  = $clog2(CAP / 2 + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = 2'b00;
  logic [XLEN-1:0] cmd_operand = '0;
  logic            rsp_valid, rsp_illegal, vu_enabled, clip_mode;
  logic [XLEN-1:0] rsp_result;
  logic [4:0]      vreg_top;
  logic [1:0]      ew_code, round_mode;
  logic [VLW-1:0]  max_vl, cur_vl;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  vcfg_len_ctrl #(.XLEN(XLEN), .CAP_BYTES(CAP)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_operand(cmd_operand), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
    .rsp_illegal(rsp_illegal), .vu_enabled(vu_enabled), .vreg_top(vreg_top),
    .ew_code(ew_code), .clip_mode(clip_mode), .round_mode(round_mode),
    .max_vl(max_vl), .cur_vl(cur_vl)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive on a falling edge; the answer is registered at the next rising
  // edge, so it is sampled on the falling edge after that.
  task automatic issue(input logic [1:0] op, input logic [XLEN-1:0] opnd);
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_op      = op;
    cmd_operand = opnd;
    @(negedge clk);
    cmd_valid   = 1'b0;
  endtask

  int exp_vl;

  task automatic legal_rsp(input string req, input longint res);
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " rsp_illegal"}, rsp_illegal, 0);
    chk({req, " result"}, rsp_result, res);
  endtask

  function automatic longint min_len(input longint a, input longint b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 enabled", vu_enabled, 0);
    chk("R1 vreg_top", vreg_top, 0);
    chk("R1 ew_code", ew_code, 0);
    chk("R1 clip", clip_mode, 0);
    chk("R1 round", round_mode, 0);
    chk("R1 max_vl", max_vl, 0);
    chk("R1 cur_vl", cur_vl, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 rsp_illegal", rsp_illegal, 0);

    // R9: disabled straight out of reset
    issue(2'b10, 0);
    chk("R9 read illegal", rsp_illegal, 1);
    chk("R9 read result", rsp_result, 0);

    for (int imm = 0; imm < 256; imm++) begin
      int top, code, ebytes, emax;
      longint ops [7];
      top    = imm & 31;
      code   = (imm >> 5) & 3;
      ebytes = (code == 0) ? 8 : (1 << (code - 1));
      emax   = (top == 0) ? 0 : CAP / ((top + 1) * ebytes);
      issue(2'b00, XLEN'(imm));
      if (top != 0) begin
        legal_rsp("R5 cfg", emax);
        chk("R2 enabled", vu_enabled, 1);
        chk("R2 vreg_top", vreg_top, top);
        chk("R2 ew_code", ew_code, code);
        chk("R2 clip", clip_mode, (imm >> 7) & 1);
        chk("R2 round", round_mode, 2);
        chk("R4 max_vl", max_vl, emax);
        chk("R5 cur_vl", cur_vl, emax);
        exp_vl = emax;
        issue(2'b10, 32'hDEAD_BEEF);
        legal_rsp("R7 read", exp_vl);
        chk("R7 vl kept", cur_vl, exp_vl);
        ops = '{0, 1, emax - 1, emax, emax + 1, 64'h8000_0000, 64'hFFFF_FFFF};
        foreach (ops[k]) begin
          exp_vl = int'(min_len(ops[k], emax));
          issue(2'b01, XLEN'(ops[k]));
          legal_rsp("R6 setvl", exp_vl);
          chk("R6 cur_vl", cur_vl, exp_vl);
        end
        issue(2'b11, 32'hFFFF_FFF0);
        legal_rsp("R8 write old", exp_vl);
        chk("R8 write capped", cur_vl, emax);
        exp_vl = emax;
        issue(2'b11, XLEN'(emax > 1 ? emax - 1 : 0));
        legal_rsp("R8 write old2", exp_vl);
        chk("R8 write below", cur_vl, emax > 1 ? emax - 1 : 0);
      end else begin
        chk("R3 rsp_valid", rsp_valid, 1);
        chk("R3 rsp_illegal", rsp_illegal, 0);
        chk("R3 result", rsp_result, 0);
        chk("R3 enabled", vu_enabled, 0);
        chk("R3 fields", {vreg_top, ew_code, clip_mode, round_mode}, 0);
        chk("R3 max_vl", max_vl, 0);
        chk("R3 cur_vl", cur_vl, 0);
        issue(2'b01, 7);
        chk("R9 setvl illegal", rsp_illegal, 1);
        chk("R9 setvl result", rsp_result, 0);
        chk("R9 setvl vl", cur_vl, 0);
        issue(2'b11, 9);
        chk("R9 write illegal", rsp_illegal, 1);
        chk("R9 write result", rsp_result, 0);
        chk("R9 write vl", cur_vl, 0);
        issue(2'b10, 0);
        chk("R9 read illegal", rsp_illegal, 1);
      end
    end

    // R10: response is a single-cycle pulse
    issue(2'b00, 32'h0000_0063);
    chk("R10 valid on answer", rsp_valid, 1);
    @(negedge clk);
    chk("R10 valid drops", rsp_valid, 0);
    chk("R10 illegal low idle", rsp_illegal, 0);
    chk("R4 4 regs 4 bytes", max_vl, CAP / (4 * 4));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule